// File: doc/BRIEF.md
# Ring Worker Node Controller

This block is one intermediate station on a one-way instruction ring. Symbols arrive from the upstream neighbour. Each symbol carries a byte value `v` encoded as the odd code `2*v+1`, so a code of zero means the channel is empty. In its idle state the node decodes a kind byte. A kind-1 message is followed by an instruction byte. The node forwards that instruction to its downstream neighbour, then issues a one-cycle execute strobe carrying the instruction. A kind-2 message is a news item: an address byte followed by a data byte. The node consumes it as a no-operation execute and forwards nothing.

When the executed instruction is the route opcode, the node sends a news message downstream. The message is a kind-2 symbol followed by two payload bytes, which are sampled from an input port at execute time. The node holds its ready output to upstream low from the moment an instruction or news item has been taken until the whole forward, execute and send sequence is finished. It sends a symbol only while the downstream ready input is high. The reserved code 2 is an end-of-stream marker: the node passes it on and then stops responding for good.

Top module: `ring_node`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `rdy_up` is 1, and `tx_valid` and `exec_stb` are 0.
- R2: An odd received code carries the value `code>>1`. A received code of 0, or of any even value other than 2, is treated as no symbol. Every transmitted value symbol is `2*v+1`, and every transmitted symbol is either odd or exactly 2.
- R3: In idle, a value symbol of 1 starts an instruction message and a value symbol of 2 starts a news message. Any other value is dropped, and the node stays idle.
- R4: After the instruction byte `i` is taken, `rdy_up` is 0 from the next cycle. The node then sends code 3 followed by `2*i+1`, and it does so before the execute strobe.
- R5: Each accepted instruction or news item produces exactly one single-cycle `exec_stb`, with `exec_instr` equal to the instruction. A news item produces instruction 0 and no transmitted symbol.
- R6: When the executed instruction equals 4, the node then sends code 5, followed by `2*p[7:0]+1` and then `2*p[15:8]+1`. Here `p` is the value of `news_payload` on the clock edge that ends the strobe cycle. No other instruction sends anything after its forward.
- R7: A symbol appears on `tx_valid` only if `rdy_dn` was high in the cycle before. While `rdy_dn` stays low, nothing is sent and nothing is executed.
- R8: If `rdy_dn` is low in a cycle where the second or third symbol of a message would be sent, the node resends that message starting from its kind symbol.
- R9: `rdy_up` rises again in the same cycle as the last news symbol for a route instruction, or in the cycle after the strobe for any other instruction. It does not rise earlier.
- R10: Symbols that arrive while `rdy_up` is 0 are ignored.
- R11: In idle, received code 2 is sent downstream as code 2 once `rdy_dn` is high. After that the node never transmits or executes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received code present this cycle |
| rx_code | input | 9 | Received line code |
| rdy_up | output | 1 | Ready toward upstream neighbour |
| tx_valid | output | 1 | Transmitted code present this cycle |
| tx_code | output | 9 | Transmitted line code |
| rdy_dn | input | 1 | Ready from downstream neighbour |
| exec_stb | output | 1 | One-cycle execute strobe |
| exec_instr | output | 8 | Instruction being executed |
| news_payload | input | 16 | Two news bytes, low byte sent first |

## Verification
The hardest case to reach is the restart in the middle of a message. Downstream ready has to fall in exactly the cycle after a kind symbol has gone out, which is a window of one cycle that is visible only at the transmit port. The bench watches the transmit log and drops `rdy_dn` at the sample point where the kind symbol first appears. It does this once during an instruction forward and once during a news message. In the news case it also changes the payload during the stall, to confirm that the bytes sent after the restart are the ones sampled at execute.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;

  // Raw line code reserved as end-of-stream marker (never a value symbol)
  localparam int LINE_END = 2;

  typedef enum logic [3:0] {
    S_IDLE,
    S_GET_INSTR,
    S_GET_ADDR,
    S_GET_DATA,
    S_FWD_KIND,
    S_FWD_INSTR,
    S_EXEC,
    S_NEWS_KIND,
    S_NEWS_LO,
    S_NEWS_HI,
    S_HALT_TX,
    S_HALTED
  } node_state_t;

endpackage

// File: rtl/ring_rx_decode.sv
module ring_rx_decode #(
  parameter int BYTE_W = 8
) (
  input  logic              rx_valid,
  input  logic [BYTE_W:0]   rx_code,
  output logic              is_data,
  output logic              is_end,
  output logic [BYTE_W-1:0] value
);
  import ring_node_pkg::*;

  localparam int SYM_W = BYTE_W + 1;

  // Odd codes carry a byte; one even code marks end of stream; all else empty
  always_comb begin
    is_data = rx_valid && rx_code[0];
    is_end  = rx_valid && (rx_code == SYM_W'(LINE_END));
    value   = rx_code[SYM_W-1:1];
  end

endmodule

// File: rtl/ring_tx_stage.sv
module ring_tx_stage #(
  parameter int BYTE_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            send,
  input  logic [BYTE_W:0] send_sym,
  output logic            tx_valid,
  output logic [BYTE_W:0] tx_code
);
  import ring_node_pkg::*;

  localparam int SYM_W = BYTE_W + 1;

  logic end_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_code  <= '0;
      end_seen <= 1'b0;
    end else begin
      tx_valid <= send;
      tx_code  <= send ? send_sym : '0;
      if (tx_valid && tx_code == SYM_W'(LINE_END))
        end_seen <= 1'b1;
    end
  end

  AST_TX_ENCODED: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_code[0] || tx_code == SYM_W'(LINE_END))); // R2

  AST_END_FINAL: assert property (@(posedge clk) disable iff (rst)
    end_seen |-> !tx_valid); // R11

endmodule

// File: rtl/ring_node_fsm.sv
module ring_node_fsm #(
  parameter int BYTE_W     = 8,
  parameter int ROUTE_OP   = 4,
  parameter int KIND_INSTR = 1,
  parameter int KIND_NEWS  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                is_data,
  input  logic                is_end,
  input  logic [BYTE_W-1:0]   value,
  input  logic                rdy_dn,
  input  logic [2*BYTE_W-1:0] news_payload,
  output logic                send,
  output logic [BYTE_W:0]     send_sym,
  output logic                rdy_up,
  output logic                exec_stb,
  output logic [BYTE_W-1:0]   exec_instr
);
  import ring_node_pkg::*;

  localparam int SYM_W = BYTE_W + 1;

  node_state_t st, nxt;
  logic [BYTE_W-1:0]   instr_q;
  logic [2*BYTE_W-1:0] pay_q;
  logic                is_route;

  function automatic logic [SYM_W-1:0] enc(input logic [BYTE_W-1:0] v);
    return {v, 1'b1};
  endfunction

  assign is_route = (instr_q == BYTE_W'(ROUTE_OP));

  always_comb begin
    nxt      = st;
    send     = 1'b0;
    send_sym = '0;
    case (st)
      S_IDLE: begin
        if (is_end) nxt = S_HALT_TX;
        else if (is_data) begin
          if (value == BYTE_W'(KIND_INSTR))     nxt = S_GET_INSTR;
          else if (value == BYTE_W'(KIND_NEWS)) nxt = S_GET_ADDR;
        end
      end
      S_GET_INSTR: if (is_data) nxt = S_FWD_KIND;
      S_GET_ADDR:  if (is_data) nxt = S_GET_DATA;
      S_GET_DATA:  if (is_data) nxt = S_EXEC;
      S_FWD_KIND: begin
        if (rdy_dn) begin
          send = 1'b1; send_sym = enc(BYTE_W'(KIND_INSTR)); nxt = S_FWD_INSTR;
        end
      end
      S_FWD_INSTR: begin
        if (!rdy_dn) nxt = S_FWD_KIND;
        else begin
          send = 1'b1; send_sym = enc(instr_q); nxt = S_EXEC;
        end
      end
      S_EXEC: nxt = is_route ? S_NEWS_KIND : S_IDLE;
      S_NEWS_KIND: begin
        if (rdy_dn) begin
          send = 1'b1; send_sym = enc(BYTE_W'(KIND_NEWS)); nxt = S_NEWS_LO;
        end
      end
      S_NEWS_LO: begin
        if (!rdy_dn) nxt = S_NEWS_KIND;
        else begin
          send = 1'b1; send_sym = enc(pay_q[BYTE_W-1:0]); nxt = S_NEWS_HI;
        end
      end
      S_NEWS_HI: begin
        if (!rdy_dn) nxt = S_NEWS_KIND;
        else begin
          send = 1'b1; send_sym = enc(pay_q[2*BYTE_W-1:BYTE_W]); nxt = S_IDLE;
        end
      end
      S_HALT_TX: begin
        if (rdy_dn) begin
          send = 1'b1; send_sym = SYM_W'(LINE_END); nxt = S_HALTED;
        end
      end
      S_HALTED: nxt = S_HALTED;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      instr_q  <= '0;
      pay_q    <= '0;
      rdy_up   <= 1'b1;
      exec_stb <= 1'b0;
    end else begin
      st       <= nxt;
      exec_stb <= (nxt == S_EXEC) && (st != S_EXEC);
      rdy_up   <= (nxt == S_IDLE) || (nxt == S_GET_INSTR) || (nxt == S_GET_ADDR) ||
                  (nxt == S_GET_DATA) || (nxt == S_HALT_TX) || (nxt == S_HALTED);
      if (st == S_GET_INSTR && is_data) instr_q <= value;
      if (st == S_GET_DATA && is_data)  instr_q <= '0;
      if (st == S_EXEC && is_route)     pay_q   <= news_payload;
    end
  end

  assign exec_instr = instr_q;

  AST_EXEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    exec_stb |=> !exec_stb); // R5

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (st == S_HALTED) |-> (!send && !exec_stb)); // R11

endmodule

// File: rtl/ring_node.sv
module ring_node #(
  parameter int BYTE_W     = 8,
  parameter int ROUTE_OP   = 4,
  parameter int KIND_INSTR = 1,
  parameter int KIND_NEWS  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_valid,
  input  logic [BYTE_W:0]     rx_code,
  output logic                rdy_up,
  output logic                tx_valid,
  output logic [BYTE_W:0]     tx_code,
  input  logic                rdy_dn,
  output logic                exec_stb,
  output logic [BYTE_W-1:0]   exec_instr,
  input  logic [2*BYTE_W-1:0] news_payload
);

  localparam int SYM_W = BYTE_W + 1;

  logic              is_data, is_end;
  logic [BYTE_W-1:0] value;
  logic              send;
  logic [SYM_W-1:0]  send_sym;

  ring_rx_decode #(.BYTE_W(BYTE_W)) u_dec (
    .rx_valid(rx_valid), .rx_code(rx_code),
    .is_data(is_data), .is_end(is_end), .value(value)
  );

  ring_node_fsm #(
    .BYTE_W(BYTE_W), .ROUTE_OP(ROUTE_OP),
    .KIND_INSTR(KIND_INSTR), .KIND_NEWS(KIND_NEWS)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .is_data(is_data), .is_end(is_end), .value(value),
    .rdy_dn(rdy_dn), .news_payload(news_payload),
    .send(send), .send_sym(send_sym),
    .rdy_up(rdy_up), .exec_stb(exec_stb), .exec_instr(exec_instr)
  );

  ring_tx_stage #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst(rst), .send(send), .send_sym(send_sym),
    .tx_valid(tx_valid), .tx_code(tx_code)
  );

  AST_EXEC_STALLS: assert property (@(posedge clk) disable iff (rst)
    exec_stb |-> !rdy_up); // R4

  AST_TX_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(rdy_dn)); // R7

  AST_RDY_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_up) |-> ($past(exec_stb) || tx_valid)); // R9

endmodule

// File: tb/ring_node_bench.sv
module ring_node_bench;

  localparam int CLK_NS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [8:0]  rx_code = '0;
  logic        rdy_dn = 1'b1;
  logic [15:0] news_payload = '0;
  logic        rdy_up, tx_valid, exec_stb;
  logic [8:0]  tx_code;
  logic [7:0]  exec_instr;

  int checks = 0;
  int errors = 0;
  int tx_n = 0;
  int ex_n = 0;
  int tx_log [256];
  int ex_log [256];

  always #(CLK_NS/2) clk = ~clk;

  ring_node u_ring_node (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_code(rx_code),
    .rdy_up(rdy_up), .tx_valid(tx_valid), .tx_code(tx_code),
    .rdy_dn(rdy_dn), .exec_stb(exec_stb), .exec_instr(exec_instr),
    .news_payload(news_payload)
  );

  // Monitor on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_valid) begin
        if (tx_n < 256) tx_log[tx_n] = int'(tx_code);
        tx_n++;
      end
      if (exec_stb) begin
        if (ex_n < 256) ex_log[ex_n] = int'(exec_instr);
        ex_n++;
      end
    end
  end

  localparam int NV = 6;
  localparam int VEC_INSTR [NV] = '{4, 0, 3, 4, 5, 255};
  localparam int VEC_PAY   [NV] = '{16'hA53C, 16'h1111, 16'h2222, 16'h00FF, 16'h3333, 16'h4444};
  localparam int VEC_NTX   [NV] = '{5, 2, 2, 5, 2, 2};

  function automatic int enc(input int v);
    return 2 * v + 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic put(input int code);
    rx_valid = 1'b1;
    rx_code  = 9'(code);
    @(negedge clk); #1;
    rx_valid = 1'b0;
    rx_code  = '0;
  endtask

  task automatic wait_tx(input int target);
    for (int k = 0; k < 40 && tx_n < target; k++) begin
      @(negedge clk); #1;
    end
  endtask

  function automatic int logv(input int idx);
    return (idx < 256) ? tx_log[idx] : -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base, eb;
    repeat (3) @(negedge clk);
    #1;
    check("R1 rdy_up in reset", int'(rdy_up), 1);
    check("R1 tx_valid in reset", int'(tx_valid), 0);
    rst = 1'b0;
    idle(1);
    check("R1 rdy_up after reset", int'(rdy_up), 1);
    check("R1 tx_valid after reset", int'(tx_valid), 0);
    check("R1 exec_stb after reset", int'(exec_stb), 0);

    // Table-driven instruction vectors: R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      base = tx_n; eb = ex_n;
      news_payload = 16'(VEC_PAY[i]);
      put(enc(1));
      put(enc(VEC_INSTR[i]));
      check("R4 ready low after instruction", int'(rdy_up), 0);
      idle(12);
      check("R6 symbol count", tx_n - base, VEC_NTX[i]);
      check("R4 forwarded kind", logv(base), 3);
      check("R4 forwarded instruction", logv(base + 1), enc(VEC_INSTR[i]));
      if (VEC_INSTR[i] == 4) begin
        check("R6 news kind", logv(base + 2), 5);
        check("R6 payload low", logv(base + 3), enc(VEC_PAY[i] & 255));
        check("R6 payload high", logv(base + 4), enc((VEC_PAY[i] >> 8) & 255));
      end
      check("R5 one strobe", ex_n - eb, 1);
      check("R5 strobe instruction", (eb < 256) ? ex_log[eb] : -1, VEC_INSTR[i]);
      check("R9 ready restored", int'(rdy_up), 1);
    end

    // R5: news item is a silent no-operation execute
    base = tx_n; eb = ex_n;
    put(enc(2)); put(enc(8'h21)); put(enc(8'h77));
    check("R5 ready low on news data", int'(rdy_up), 0);
    idle(6);
    check("R5 news forwards nothing", tx_n - base, 0);
    check("R5 news strobe count", ex_n - eb, 1);
    check("R5 news strobe is zero", (eb < 256) ? ex_log[eb] : -1, 0);
    check("R9 ready after news", int'(rdy_up), 1);

    // R2 R3: bad kind and empty codes ignored in idle
    base = tx_n;
    put(enc(3)); put(0); put(4); put(enc(1)); put(enc(0));
    idle(8);
    check("R3 only one message sent", tx_n - base, 2);
    check("R3 kind after bad kind", logv(base), 3);
    check("R2 empty codes skipped", logv(base + 1), 1);

    // R7 R10: downstream stall, junk from upstream while stalled
    base = tx_n; eb = ex_n;
    news_payload = 16'h0102;
    rdy_dn = 1'b0;
    put(enc(1)); put(enc(4));
    idle(6);
    check("R7 nothing sent while stalled", tx_n - base, 0);
    check("R7 no execute while stalled", ex_n - eb, 0);
    check("R4 ready low while stalled", int'(rdy_up), 0);
    put(enc(1)); put(enc(6));
    rdy_dn = 1'b1;
    idle(14);
    check("R10 junk ignored count", tx_n - base, 5);
    check("R10 forwarded instruction", logv(base + 1), enc(4));
    check("R10 payload low", logv(base + 3), enc(2));
    check("R10 payload high", logv(base + 4), enc(1));
    check("R10 single execute", ex_n - eb, 1);

    // R8: restart in the instruction forward
    base = tx_n; eb = ex_n;
    put(enc(1)); put(enc(7));
    wait_tx(base + 1);
    rdy_dn = 1'b0;
    idle(3);
    check("R8 held after kind", tx_n - base, 1);
    rdy_dn = 1'b1;
    idle(10);
    check("R8 fwd restart count", tx_n - base, 3);
    check("R8 kind resent", logv(base + 1), 3);
    check("R8 instruction after restart", logv(base + 2), enc(7));
    check("R8 one execute", ex_n - eb, 1);

    // R8 R6 R9: restart in news message, payload changed during stall
    base = tx_n;
    news_payload = 16'h1234;
    put(enc(1)); put(enc(4));
    wait_tx(base + 3);
    rdy_dn = 1'b0;
    news_payload = 16'hBEEF;
    idle(4);
    check("R8 news held after kind", tx_n - base, 3);
    check("R9 ready low mid message", int'(rdy_up), 0);
    rdy_dn = 1'b1;
    idle(10);
    check("R8 news restart count", tx_n - base, 6);
    check("R8 news kind resent", logv(base + 3), 5);
    check("R6 sampled payload low", logv(base + 4), enc(8'h34));
    check("R6 sampled payload high", logv(base + 5), enc(8'h12));
    check("R9 ready after restart", int'(rdy_up), 1);

    // R11: end marker waits for ready, then node goes silent
    base = tx_n; eb = ex_n;
    rdy_dn = 1'b0;
    put(2);
    idle(3);
    check("R11 marker waits for ready", tx_n - base, 0);
    rdy_dn = 1'b1;
    idle(3);
    check("R11 marker forwarded", tx_n - base, 1);
    check("R11 marker code", logv(base), 2);
    put(enc(1)); put(enc(0)); put(enc(2));
    idle(10);
    check("R11 silent after marker", tx_n - base, 1);
    check("R11 no execute after marker", ex_n - eb, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule